// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, based on its 48-bit destination address. The address arrives one byte per accepted beat. A start-of-frame strobe marks the first byte. A CRC-32 over the address is computed as the bytes arrive, so a single registered accept/reject result is ready in the cycle that follows the sixth byte.

Frames fall into one of three classes: broadcast, multicast or unicast. Each class has its own enable. Two further controls override the class rules: a promiscuous control that takes every frame, and a filter enable whose clear state also takes every frame. Multicast frames can also be narrowed by a 64-bin hash table. The table is supplied as two 32-bit words and indexed by six bits of the CRC. Unicast frames can be compared against a programmed station address. The block does not check the frame check sequence.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid_o` and `accept_o` are 0. Bytes that arrive without a start strobe, before any frame has begun, are ignored and produce no decision.
- R2: The decision appears in the cycle after the clock edge that captures the sixth address byte, however many idle beats fall between the bytes. It stays unchanged until a start-strobed byte is captured. That byte clears `dec_valid_o` and `accept_o` on the same edge.
- R3: With `promisc_en_i` = 1, every frame is accepted, whatever the other controls are.
- R4: With `promisc_en_i` = 0 and `filt_en_i` = 0, every frame is accepted.
- R5: A frame whose 48 address bits are all 1 is broadcast. With filtering active, it is accepted exactly when `bcast_en_i` = 1.
- R6: A frame is multicast when bit 0 of its first address byte is 1 and it is not broadcast. With filtering active and `mcast_en_i` = 0, it is rejected.
- R7: A multicast frame with `mcast_en_i` = 1 and `hash_en_i` = 0 is accepted without consulting the table.
- R8: With `mcast_en_i` = 1 and `hash_en_i` = 1, a multicast frame is accepted exactly when one table bit is 1. The bit is chosen by index k, formed from bits 31:26 of a CRC computed as follows: polynomial 0x04C11DB7, register preset to all ones, no final inversion, shifted MSB-first, bytes fed first-byte-first with each byte's bit 0 first. Bit k[5] selects `hash_tbl1_i` (1) or `hash_tbl0_i` (0), and k[4:0] is the bit position within that word.
- R9: With filtering active and `ucast_chk_i` = 1, a unicast frame is accepted exactly when its address equals the station address. Address byte 0 is `sta_hi_i[23:16]`, byte 2 is `sta_hi_i[7:0]`, byte 3 is `sta_lo_i[23:16]`, and byte 5 is `sta_lo_i[7:0]`.
- R10: With filtering active and `ucast_chk_i` = 0, every unicast frame is accepted.
- R11: Bytes after the sixth and before the next start strobe do not change the held decision. A start strobe partway through an address discards the partial address and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the current byte as address byte 0. Only meaningful when `byte_valid_i` is 1. |
| byte_valid_i | input | 1 | Byte beat qualifier |
| byte_i | input | 8 | Address byte |
| promisc_en_i | input | 1 | Accept every frame |
| filt_en_i | input | 1 | Destination filtering active |
| ucast_chk_i | input | 1 | Compare unicast addresses against the station address |
| mcast_en_i | input | 1 | Allow multicast frames |
| hash_en_i | input | 1 | Gate multicast frames through the hash table |
| bcast_en_i | input | 1 | Allow broadcast frames |
| hash_tbl0_i | input | 32 | Hash bins 0 to 31 |
| hash_tbl1_i | input | 32 | Hash bins 32 to 63 |
| sta_hi_i | input | 24 | Station address bytes 0 to 2 |
| sta_lo_i | input | 24 | Station address bytes 3 to 5 |
| dec_valid_o | output | 1 | A decision is being held |
| accept_o | output | 1 | Frame accepted; 0 whenever `dec_valid_o` is 0 |

## Verification
The assertions check the control-level rules on every cycle. These are:
- the promiscuous and filter-off overrides;
- `accept_o` never being 1 without a valid decision;
- a start strobe clearing the decision;
- a held decision staying stable until the next start strobe.

The address-dependent outcomes can only be shown by the bench's scenarios: the CRC bin selection, the word and bit split of the hash table, the station compare byte order, and the broadcast and multicast classification. In those scenarios a behavioural model predicts the outputs every cycle, for idle gaps, overlong addresses and restarted addresses.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;

  typedef struct packed {
    logic promisc;
    logic filt;
    logic ucast;
    logic mcast;
    logic hash;
    logic bcast;
  } rx_af_cfg_t;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } addr_class_e;

endpackage

// File: rtl/rx_af_crc_step.sv
module rx_af_crc_step #(
  parameter int          CRC_W = 32,
  parameter int          DAT_W = 8,
  parameter logic [31:0] POLY  = 32'h04C11DB7
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DAT_W-1:0] data_i,
  output logic [CRC_W-1:0] crc_o
);

  localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];

  // data bit 0 enters first; register shifts toward its MSB
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_i;
    for (int i = 0; i < DAT_W; i++) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY_W;
    end
    crc_o = c;
  end

endmodule

// File: rtl/rx_af_decide.sv
module rx_af_decide
  import rx_af_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 6,
  localparam int TBL_W = 2 ** (HASH_W - 1)
) (
  input  rx_af_cfg_t        cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HASH_W-1:0] idx_i,
  input  logic [TBL_W-1:0]  tbl0_i,
  input  logic [TBL_W-1:0]  tbl1_i,
  input  logic [ADDR_W-1:0] station_i,
  output logic              accept_o
);

  addr_class_e     cls;
  logic [TBL_W-1:0] tbl_sel;
  logic            bin_hit;

  always_comb begin
    if (&addr_i)                 cls = CLS_BCAST;
    else if (addr_i[ADDR_W - 8]) cls = CLS_MULTI;  // bit 0 of first byte
    else                         cls = CLS_UNI;
  end

  assign tbl_sel = idx_i[HASH_W-1] ? tbl1_i : tbl0_i;
  assign bin_hit = tbl_sel[idx_i[HASH_W-2:0]];

  always_comb begin
    if (cfg_i.promisc || !cfg_i.filt) begin
      accept_o = 1'b1;
    end else begin
      unique case (cls)
        CLS_BCAST: accept_o = cfg_i.bcast;
        CLS_MULTI: accept_o = cfg_i.mcast && (!cfg_i.hash || bin_hit);
        default:   accept_o = !cfg_i.ucast || (addr_i == station_i);
      endcase
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int CRC_W      = 32,
  parameter int HASH_W     = 6,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int TBL_W     = 2 ** (HASH_W - 1),
  localparam int HALF_W    = ADDR_W / 2,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              promisc_en_i,
  input  logic              filt_en_i,
  input  logic              ucast_chk_i,
  input  logic              mcast_en_i,
  input  logic              hash_en_i,
  input  logic              bcast_en_i,
  input  logic [TBL_W-1:0]  hash_tbl0_i,
  input  logic [TBL_W-1:0]  hash_tbl1_i,
  input  logic [HALF_W-1:0] sta_hi_i,
  input  logic [HALF_W-1:0] sta_lo_i,
  output logic              dec_valid_o,
  output logic              accept_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CRC_W-1:0]  crc_q, crc_base, crc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              first, take, last, acc_d;
  logic              valid_q, acc_q;
  rx_af_cfg_t        cfg;

  assign cfg = '{promisc: promisc_en_i, filt: filt_en_i, ucast: ucast_chk_i,
                 mcast: mcast_en_i, hash: hash_en_i, bcast: bcast_en_i};

  assign first    = byte_valid_i && sof_i;
  assign take     = byte_valid_i && (sof_i || cnt_q < CNT_FULL);
  assign cnt_d    = first ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign last     = take && (cnt_d == CNT_FULL);
  assign crc_base = first ? '1 : crc_q;
  assign addr_d   = {addr_q[ADDR_W-9:0], byte_i};

  rx_af_crc_step #(.CRC_W(CRC_W), .DAT_W(8)) u_crc (
    .crc_i  (crc_base),
    .data_i (byte_i),
    .crc_o  (crc_d)
  );

  rx_af_decide #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_dec (
    .cfg_i     (cfg),
    .addr_i    (addr_d),
    .idx_i     (crc_d[CRC_W-1 -: HASH_W]),
    .tbl0_i    (hash_tbl0_i),
    .tbl1_i    (hash_tbl1_i),
    .station_i ({sta_hi_i, sta_lo_i}),
    .accept_o  (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_FULL;
      crc_q  <= '1;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else if (last) begin
      valid_q <= 1'b1;
      acc_q   <= acc_d;
    end else if (first) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end
  end

  assign dec_valid_o = valid_q;
  assign accept_o    = acc_q;

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sof_i,
  input logic byte_valid_i,
  input logic promisc_en_i,
  input logic filt_en_i,
  input logic dec_valid_o,
  input logic accept_o
);

  a_r1_accept_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> dec_valid_o);

  a_r2_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && sof_i) |=> !dec_valid_o && !accept_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !(byte_valid_i && sof_i)) |=> dec_valid_o && $stable(accept_o));

  a_r3_promisc_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_valid_o) && $past(promisc_en_i)) |-> accept_o);

  a_r4_filter_off_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_valid_o) && !$past(filt_en_i)) |-> accept_o);

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (.*);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sof = 1'b0, bv = 1'b0;
  logic [7:0]  bt = '0;
  logic        c_pro = 0, c_filt = 0, c_uc = 0, c_mc = 0, c_hash = 0, c_bc = 0;
  logic [31:0] t0 = '0, t1 = '0;
  logic [23:0] s_hi = 24'h02AB34, s_lo = 24'h56CD78;
  logic        dvalid, acc;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(bv), .byte_i(bt),
    .promisc_en_i(c_pro), .filt_en_i(c_filt), .ucast_chk_i(c_uc),
    .mcast_en_i(c_mc), .hash_en_i(c_hash), .bcast_en_i(c_bc),
    .hash_tbl0_i(t0), .hash_tbl1_i(t1), .sta_hi_i(s_hi), .sta_lo_i(s_lo),
    .dec_valid_o(dvalid), .accept_o(acc)
  );

  function automatic int bin_of(bit [47:0] a);
    bit [31:0] c = '1;
    for (int i = 0; i < 6; i++) begin
      bit [7:0] b = a[47 - 8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        bit fb = c[31] ^ b[k];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return int'(c[31:26]);
  endfunction

  function automatic bit ref_accept(bit [47:0] a);
    int k;
    if (c_pro || !c_filt) return 1;
    if (a == '1) return c_bc;
    if (a[40]) begin
      if (!c_mc) return 0;
      if (!c_hash) return 1;
      k = bin_of(a);
      return (k >= 32) ? t1[k-32] : t0[k];
    end
    if (!c_uc) return 1;
    return a == {s_hi, s_lo};
  endfunction

  // behavioural model, advanced on each rising edge
  bit [7:0] m_q[$];
  int       m_cnt = 6;
  bit       m_valid = 0, m_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_cnt = 6; m_valid = 0; m_acc = 0;
    end else if (bv) begin
      bit took = 0;
      if (sof) begin
        m_q.delete(); m_q.push_back(bt); m_cnt = 1; m_valid = 0; m_acc = 0; took = 1;
      end else if (m_cnt < 6) begin
        m_q.push_back(bt); m_cnt++; took = 1;
      end
      if (took && m_cnt == 6) begin
        bit [47:0] a;
        for (int i = 0; i < 6; i++) a[47 - 8*i -: 8] = m_q[i];
        m_valid = 1; m_acc = ref_accept(a);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dvalid !== m_valid) begin
        failures++;
        $display("FAIL R2 model valid act=%0d exp=%0d", dvalid, m_valid);
      end
      if (acc !== m_acc) begin
        failures++;
        $display("FAIL %s model accept act=%0d exp=%0d", tag, acc, m_acc);
      end
    end
  end

  task automatic send(bit [47:0] a, int gap = 0, int nbytes = 6, bit strobe = 1);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      bv = 1; sof = strobe && (i == 0); bt = a[47 - 8*i -: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); bv = 0; sof = 0;
      end
    end
    @(negedge clk);
    bv = 0; sof = 0;
  endtask

  task automatic expect_dec(bit v, bit ac, string r);
    checks++;
    if (dvalid !== v || acc !== ac) begin
      failures++;
      $display("FAIL %s valid/accept act=%0d/%0d exp=%0d/%0d", r, dvalid, acc, v, ac);
    end
  endtask

  task automatic cfg(bit p, bit f, bit u, bit m, bit h, bit b);
    c_pro = p; c_filt = f; c_uc = u; c_mc = m; c_hash = h; c_bc = b;
  endtask

  localparam bit [47:0] STA = 48'h02AB3456CD78;
  localparam bit [47:0] MC1 = 48'h01005E0000FB;

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    bit [47:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; expect_dec(0, 0, "R1");
    send(STA, 0, 6, 0);
    expect_dec(0, 0, "R1");

    // R9 station compare
    tag = "R9"; cfg(0, 1, 1, 1, 0, 1);
    send(STA); expect_dec(1, 1, "R9");
    send(STA ^ 48'h000000000100); expect_dec(1, 0, "R9");
    send(48'h56CD7802AB34); expect_dec(1, 0, "R9");
    // R10
    tag = "R10"; cfg(0, 1, 0, 0, 0, 0);
    send(48'h001122334455); expect_dec(1, 1, "R10");
    // R5
    tag = "R5"; cfg(0, 1, 1, 1, 0, 1);
    send('1); expect_dec(1, 1, "R5");
    cfg(0, 1, 1, 1, 0, 0);
    send('1); expect_dec(1, 0, "R5");
    // R6 / R7
    tag = "R6"; cfg(0, 1, 0, 0, 0, 1);
    send(MC1); expect_dec(1, 0, "R6");
    tag = "R7"; cfg(0, 1, 1, 1, 0, 0);
    send(MC1); expect_dec(1, 1, "R7");

    // R8 hash: only the computed bin set, then all bins but it
    tag = "R8"; cfg(0, 1, 1, 1, 1, 0);
    for (int n = 0; n < 12; n++) begin
      a = {8'h01 | 8'(n * 16), 8'h00, 8'h5E, 8'(n * 37), 8'(n * 91 + 3), 8'(n)};
      k = bin_of(a);
      t0 = '0; t1 = '0;
      if (k >= 32) t1[k-32] = 1'b1; else t0[k] = 1'b1;
      send(a); expect_dec(1, 1, "R8");
      t0 = ~t0; t1 = ~t1;
      send(a); expect_dec(1, 0, "R8");
    end
    t0 = '0; t1 = '0;

    // R3 / R4 overrides
    tag = "R3"; cfg(1, 1, 1, 0, 1, 0);
    send(MC1); expect_dec(1, 1, "R3");
    send(48'h001122334455); expect_dec(1, 1, "R3");
    tag = "R4"; cfg(0, 0, 1, 0, 1, 0);
    send('1); expect_dec(1, 1, "R4");
    send(48'h001122334455); expect_dec(1, 1, "R4");

    // R2 gaps and hold
    tag = "R2"; cfg(0, 1, 1, 0, 0, 0);
    send(STA, 2); expect_dec(1, 1, "R2");
    repeat (4) @(negedge clk);
    expect_dec(1, 1, "R2");
    @(negedge clk); bv = 1; sof = 1; bt = 8'h00;
    @(negedge clk); bv = 0; sof = 0;
    expect_dec(0, 0, "R2");

    // R11 trailing bytes and restart
    tag = "R11";
    send(STA); send(48'hFFFFFFFFFFFF, 0, 4, 0);
    expect_dec(1, 1, "R11");
    send(48'h001122334455, 0, 3);
    expect_dec(0, 0, "R11");
    send(STA); expect_dec(1, 1, "R11");
    send(STA, 0, 4); send(48'h001122334455);
    expect_dec(1, 0, "R11");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule